// File: doc/BRIEF.md
# Raster Position Capture with Byte Readout

This block freezes the horizontal and vertical raster position at the moment software asks for it, and then hands each frozen 9-bit value out through one byte-wide read port per axis. The live horizontal input is a master-cycle position inside the current line; the block scales it down to a dot position, corrects it for the memory refresh stall in the middle of each line, and stores it. The live vertical input is the current scanline number, which is stored as is.

Software issues a capture strobe and then reads each axis port twice. The first read returns the low byte and the second returns the high byte. Each axis keeps its own byte selector, so reads of one axis do not disturb the other. A capture also raises a one-cycle clear request for the pending horizontal/vertical timer interrupt flags, which are held elsewhere.

Top module: `hvlatch_top`

## Requirements
- R1: On a capture, the stored horizontal value is cyclePos divided by 4 (integer quotient) when that quotient is below 128.
- R2: When the quotient is 128 or more, 10 is added to it before storing; the sum is kept modulo 512.
- R3: On a capture, the stored vertical value is lineNum.
- R4: Each axis has its own byte selector; a read of one axis (hRead or vRead high for one cycle) returns the byte picked by that axis's selector and flips only that selector, so successive reads alternate low, high, low.
- R5: A capture returns both selectors to the low-byte state, whatever their state before.
- R6: The low byte is bits 7..0 of the stored value; the high byte carries bit 8 of the value in its bit 0 and bits 7..1 of the value in its bits 7..1.
- R7: irqFlagClr is high in exactly the cycles in which latchStrobe is high.
- R8: Stored values do not change between captures, whatever cyclePos and lineNum do.
- R9: A read in the same cycle as a capture returns the low byte of the newly captured value, and the next read of that axis returns its high byte.
- R10: After reset both stored values are 0 and both selectors are in the low-byte state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyclePos | input | CYC_W (11) | Live master-cycle position within the line |
| lineNum | input | LINE_W (9) | Live scanline number |
| latchStrobe | input | 1 | Capture request, one cycle per capture |
| hRead | input | 1 | Read of the horizontal port, one cycle per read |
| vRead | input | 1 | Read of the vertical port, one cycle per read |
| hData | output | 8 | Horizontal byte selected for the current read |
| vData | output | 8 | Vertical byte selected for the current read |
| irqFlagClr | output | 1 | Request to clear pending timer interrupt flags |

## Verification
The bench builds the block with its default parameters: an 11-bit cycle position, a divide by 4, a refresh threshold of 128 and a correction of 10. With these values the cycle input reaches 2047, so the corrected horizontal value can pass 511 and wrap, and positions on both sides of the threshold (508 and 512 cycles) plus the end of a full line are all reachable. A 9-bit scanline lets the bench set bit 8 of the vertical value and see it move to bit 0 of the high byte.

// File: rtl/hvlatch_pkg.sv
package hvlatch_pkg;

  // Width of every stored raster value
  localparam int VAL_W = 9;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // store new raster values this cycle
    logic hHigh;    // horizontal port presents the high byte
    logic vHigh;    // vertical port presents the high byte
  } hvStrobes_t;

  // Byte selection: low byte is value[7:0]; high byte holds
  // value[7:1] in bits 7..1 and value[8] in bit 0.
  function automatic logic [7:0] pickByte(input logic [VAL_W-1:0] val,
                                          input logic hi);
    pickByte = hi ? {val[7:1], val[8]} : val[7:0];
  endfunction

endpackage

// File: rtl/hvlatch_ctrl.sv
module hvlatch_ctrl
  import hvlatch_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       latchStrobe,
  input  logic       hRead,
  input  logic       vRead,
  output hvStrobes_t strobes
);

  localparam int AXES = 2;

  logic [AXES-1:0] readReq;
  logic [AXES-1:0] selQ;
  logic [AXES-1:0] selNow;

  assign readReq = {vRead, hRead};

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    // a capture forces the low byte for this cycle and the next state
    assign selNow[a] = latchStrobe ? 1'b0 : selQ[a];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        selQ[a] <= 1'b0;
      end else if (readReq[a]) begin
        selQ[a] <= ~selNow[a];
      end else begin
        selQ[a] <= selNow[a];
      end
    end
  end

  always_comb begin
    strobes.capture = latchStrobe;
    strobes.hHigh   = selNow[0];
    strobes.vHigh   = selNow[1];
  end

endmodule

// File: rtl/hvlatch_dp.sv
module hvlatch_dp
  import hvlatch_pkg::*;
#(
  parameter int CYC_W       = 11,
  parameter int LINE_W      = 9,
  parameter int DIV_SHIFT   = 2,
  parameter int REFRESH_Q   = 128,
  parameter int REFRESH_ADJ = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CYC_W-1:0]  cyclePos,
  input  logic [LINE_W-1:0] lineNum,
  input  hvStrobes_t        strobes,
  output logic [7:0]        hData,
  output logic [7:0]        vData
);

  localparam int QUOT_W = CYC_W - DIV_SHIFT;
  localparam int SUM_W  = (QUOT_W + 1 > VAL_W) ? QUOT_W + 1 : VAL_W;

  logic [QUOT_W-1:0] quot;
  logic [SUM_W-1:0]  hSum;
  logic [VAL_W-1:0]  hNew;
  logic [VAL_W-1:0]  vNew;
  logic [VAL_W-1:0]  hLat;
  logic [VAL_W-1:0]  vLat;
  logic [VAL_W-1:0]  hCur;
  logic [VAL_W-1:0]  vCur;

  // dot position with refresh-stall correction
  always_comb begin
    quot = cyclePos[CYC_W-1:DIV_SHIFT];
    hSum = SUM_W'(quot);
    if (hSum >= SUM_W'(REFRESH_Q)) begin
      hSum = hSum + SUM_W'(REFRESH_ADJ);
    end
    hNew = hSum[VAL_W-1:0];
  end

  // scanline, zero-extended or truncated to the stored width
  if (LINE_W >= VAL_W) begin : g_lineWide
    assign vNew = lineNum[VAL_W-1:0];
  end else begin : g_lineNarrow
    assign vNew = {{(VAL_W-LINE_W){1'b0}}, lineNum};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hLat <= '0;
      vLat <= '0;
    end else if (strobes.capture) begin
      hLat <= hNew;
      vLat <= vNew;
    end
  end

  // same-cycle capture and read sees the fresh value
  assign hCur = strobes.capture ? hNew : hLat;
  assign vCur = strobes.capture ? vNew : vLat;

  assign hData = pickByte(hCur, strobes.hHigh);
  assign vData = pickByte(vCur, strobes.vHigh);

endmodule

// File: rtl/hvlatch_top.sv
module hvlatch_top
  import hvlatch_pkg::*;
#(
  parameter int CYC_W       = 11,
  parameter int LINE_W      = 9,
  parameter int DIV_SHIFT   = 2,
  parameter int REFRESH_Q   = 128,
  parameter int REFRESH_ADJ = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CYC_W-1:0]  cyclePos,
  input  logic [LINE_W-1:0] lineNum,
  input  logic              latchStrobe,
  input  logic              hRead,
  input  logic              vRead,
  output logic [7:0]        hData,
  output logic [7:0]        vData,
  output logic              irqFlagClr
);

  hvStrobes_t strobes;

  hvlatch_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .latchStrobe (latchStrobe),
    .hRead       (hRead),
    .vRead       (vRead),
    .strobes     (strobes)
  );

  hvlatch_dp #(
    .CYC_W       (CYC_W),
    .LINE_W      (LINE_W),
    .DIV_SHIFT   (DIV_SHIFT),
    .REFRESH_Q   (REFRESH_Q),
    .REFRESH_ADJ (REFRESH_ADJ)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyclePos (cyclePos),
    .lineNum  (lineNum),
    .strobes  (strobes),
    .hData    (hData),
    .vData    (vData)
  );

  assign irqFlagClr = strobes.capture;

endmodule

// File: rtl/hvlatch_chk.sv
module hvlatch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       latchStrobe,
  input logic       hRead,
  input logic       vRead,
  input logic [7:0] hData,
  input logic [7:0] vData,
  input logic       irqFlagClr
);

  AST_IRQ_CLR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    irqFlagClr == latchStrobe); // R7

  AST_H_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!latchStrobe && !hRead) ##1 !latchStrobe |-> $stable(hData)); // R8

  AST_V_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!latchStrobe && !vRead) ##1 !latchStrobe |-> $stable(vData)); // R8

  AST_H_PAIR_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (hRead && !latchStrobe) ##1 (hRead && !latchStrobe)
      |-> hData[7:1] == $past(hData[7:1])); // R6

  AST_V_PAIR_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (vRead && !latchStrobe) ##1 (vRead && !latchStrobe)
      |-> vData[7:1] == $past(vData[7:1])); // R6

endmodule

bind hvlatch_top hvlatch_chk u_chk (.*);

// File: tb/sim_hvlatch_top.sv
`timescale 1ns/1ps
module sim_hvlatch_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] cyclePos = '0;
  logic [8:0]  lineNum = '0;
  logic        latchStrobe = 1'b0;
  logic        hRead = 1'b0;
  logic        vRead = 1'b0;
  logic [7:0]  hData, vData;
  logic        irqFlagClr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  hvlatch_top u0 (
    .clk(clk), .rst_n(rst_n), .cyclePos(cyclePos), .lineNum(lineNum),
    .latchStrobe(latchStrobe), .hRead(hRead), .vRead(vRead),
    .hData(hData), .vData(vData), .irqFlagClr(irqFlagClr)
  );

  // expected model from the requirements
  function automatic logic [8:0] hExp(input int cyc);
    int q;
    q = cyc / 4;
    if (q >= 128) q = q + 10;
    return 9'(q % 512);
  endfunction

  function automatic logic [7:0] loB(input logic [8:0] v);
    return v[7:0];
  endfunction

  function automatic logic [7:0] hiB(input logic [8:0] v);
    return {v[7:1], v[8]};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one cycle of stimulus; outputs sampled mid-cycle
  task automatic step(input bit lat, input bit hr, input bit vr,
                      output logic [7:0] hd, output logic [7:0] vd,
                      output logic clr);
    @(negedge clk);
    latchStrobe = lat; hRead = hr; vRead = vr;
    #2;
    hd = hData; vd = vData; clr = irqFlagClr;
    @(posedge clk);
    #1;
    latchStrobe = 1'b0; hRead = 1'b0; vRead = 1'b0;
  endtask

  task automatic capture(input int cyc, input int line);
    logic [7:0] hd, vd; logic clr;
    cyclePos = 11'(cyc); lineNum = 9'(line);
    step(1'b1, 1'b0, 1'b0, hd, vd, clr);
    chk("R7 clear during capture", clr, 1);
  endtask

  task automatic readPair(input string req, input int cyc, input int line);
    logic [7:0] hd, vd; logic clr;
    logic [8:0] he;
    he = hExp(cyc);
    step(1'b0, 1'b1, 1'b1, hd, vd, clr);
    chk({req, " H low"}, hd, loB(he));
    chk({req, " V low"}, vd, loB(9'(line)));
    chk("R7 no clear without capture", clr, 0);
    step(1'b0, 1'b1, 1'b1, hd, vd, clr);
    chk({req, " H high"}, hd, hiB(he));
    chk({req, " V high"}, vd, hiB(9'(line)));
  endtask

  task automatic tReset();
    // R10: values zero, selectors low
    readPair("R10 reset", 0, 0);
  endtask

  task automatic tBelowThreshold();
    capture(508, 5);
    readPair("R1 R3 R6 below threshold", 508, 5);
    capture(3, 1);
    readPair("R1 small position", 3, 1);
  endtask

  task automatic tAboveThreshold();
    capture(512, 300);
    readPair("R2 R3 at threshold", 512, 300);
    capture(1363, 261);
    readPair("R2 R6 bit8 set", 1363, 261);
    capture(2047, 511);
    readPair("R2 wrap modulo 512", 2047, 511);
  endtask

  task automatic tIndependent();
    logic [7:0] hd, vd; logic clr;
    capture(1000, 400);
    step(1'b0, 1'b1, 1'b0, hd, vd, clr);
    chk("R4 H first read low", hd, loB(hExp(1000)));
    step(1'b0, 1'b1, 1'b0, hd, vd, clr);
    chk("R4 H second read high", hd, hiB(hExp(1000)));
    step(1'b0, 1'b0, 1'b1, hd, vd, clr);
    chk("R4 V untouched by H reads", vd, loB(9'd400));
    step(1'b0, 1'b1, 1'b0, hd, vd, clr);
    chk("R4 H third read low", hd, loB(hExp(1000)));
    step(1'b0, 1'b0, 1'b1, hd, vd, clr);
    chk("R4 V second read high", vd, hiB(9'd400));
  endtask

  task automatic tCaptureResetsSel();
    logic [7:0] hd, vd; logic clr;
    capture(700, 200);
    step(1'b0, 1'b1, 1'b1, hd, vd, clr);  // both selectors now high
    capture(900, 150);
    step(1'b0, 1'b1, 1'b1, hd, vd, clr);
    chk("R5 H low after recapture", hd, loB(hExp(900)));
    chk("R5 V low after recapture", vd, loB(9'd150));
  endtask

  task automatic tHold();
    logic [7:0] hd, vd; logic clr;
    capture(1200, 257);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cyclePos = 11'(i * 97);
      lineNum  = 9'(i * 13);
    end
    step(1'b0, 1'b1, 1'b1, hd, vd, clr);
    chk("R8 H held", hd, loB(hExp(1200)));
    chk("R8 V held", vd, loB(9'd257));
    step(1'b0, 1'b1, 1'b1, hd, vd, clr);
    chk("R8 H high held", hd, hiB(hExp(1200)));
    chk("R8 V high held", vd, hiB(9'd257));
  endtask

  task automatic tSameCycle();
    logic [7:0] hd, vd; logic clr;
    capture(400, 10);
    step(1'b0, 1'b1, 1'b1, hd, vd, clr);  // selectors high
    cyclePos = 11'd1500; lineNum = 9'd300;
    step(1'b1, 1'b1, 1'b1, hd, vd, clr);
    chk("R9 H new low same cycle", hd, loB(hExp(1500)));
    chk("R9 V new low same cycle", vd, loB(9'd300));
    chk("R7 clear with read", clr, 1);
    step(1'b0, 1'b1, 1'b1, hd, vd, clr);
    chk("R9 H high next", hd, hiB(hExp(1500)));
    chk("R9 V high next", vd, hiB(9'd300));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tReset();
    tBelowThreshold();
    tAboveThreshold();
    tIndependent();
    tCaptureResetsSel();
    tHold();
    tSameCycle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule